// File: doc/BRIEF.md
# Indexed Indirect Effective Address Resolver

This block turns a 24-bit instruction word into the 14-bit address of its operand. It adds the index register to the address field when the word asks for indexing. When the word asks for indirection, the block reads the word at that address through a request/valid read port. It then treats the fetched word as a new address word, with its own index and indirect flags, and repeats this until it reaches a word whose indirect flag is clear. The number of levels is not limited. The address it then holds is the effective address.

An execution controller pulses `start` with the instruction word, the index register and a flag that marks a shift-class instruction. It waits for the one-cycle `done` pulse and then reads `ea` together with `ind_levels`, the number of indirect levels taken. The controller uses that count to account for the extra memory cycles. The installed memory size is a parameter. An address at or above it behaves as a word of zero, and no read is issued for it.

Top module: `ea_resolver`

## Requirements
- R1: Bit positions are counted from the most significant bit as position 0. The index flag is position 1 (vector bit 22), the indirect flag is position 9 (vector bit 14), and positions 10 to 23 (vector bits 13:0) hold the 14-bit address. All other bits of any address word are ignored.
- R2: When the index flag is set, bits 13:0 of the index register are added to the address field modulo 2^14, and any carry out is dropped.
- R3: A word with the indirect flag clear completes with `done` high in the cycle after the `start` edge, with `ind_levels` = 0 and no memory request.
- R4: When a word is both indexed and indirect, the read request goes to the indexed address.
- R5: Each fetched word is decoded again for its own index and indirect flags, to any depth. `ind_levels` equals the number of indirect words followed.
- R6: For a shift-class instruction word that is indexed and not indirect, only address bits 5:0 take the sum of the address and the index, modulo 64. Bits 13:6, including the shift-mode bits 13:12, pass through unchanged.
- R7: The shift-class flag applies only to the instruction word. An indexed, indirect shift-class word and every fetched word use the full 14-bit indexing.
- R8: An address at or above MEM_WORDS issues no request and is treated as a fetched word of zero, so it resolves to address 0. It counts as one level and costs one cycle.
- R9: `mem_req` stays high with `mem_addr` stable until `mem_valid` is seen. An in-range level costs one cycle plus the wait for `mem_valid`.
- R10: `done` is a one-cycle pulse per resolution. `ea` and `ind_levels` change only in a cycle where `done` is high, and hold their values until the next one.
- R11: While `rst_n` is low, `done` and `mem_req` are low and `ea` and `ind_levels` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (taken while idle) |
| instr | input | 24 | Instruction word |
| xreg | input | 24 | Index register |
| shift_op | input | 1 | Instruction is shift-class |
| mem_req | output | 1 | Read request |
| mem_addr | output | 14 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 24 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 14 | Effective address |
| ind_levels | output | LVL_W | Indirect levels taken (saturating) |

## Verification
The tests apply a range of input patterns, each chosen to separate one behaviour from its neighbours:
- A plain direct word and an indexed word that wraps past the top of the address space tell proper modulo addition apart from carry leakage.
- A single indirect word, and an indexed indirect word, show whether indexing happens before the fetch.
- A three-level chain whose middle word carries its own index flag, read with added read latency, checks re-decoding, the level count and the cycle cost.
- The same shift-class word is resolved with the flag set and with it clear, which makes the six-bit indexing visible. A shift-class indirect word checks that the narrow form is not applied there.
- Addresses above the installed size, both directly and partway down a chain, are backed by non-zero bench data. This shows whether a forbidden read took place.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W  = 24;
  localparam int AW      = 14;
  localparam int SHF_W   = 6;
  localparam int IDX_BIT = WORD_W - 2;       // position 1 from the MSB
  localparam int IND_BIT = WORD_W - 1 - 9;   // position 9 from the MSB

  typedef struct packed {
    logic          ind;
    logic [AW-1:0] addr;
  } ea_word_t;

  typedef enum logic {ST_IDLE, ST_READ} ea_state_t;
endpackage

// File: rtl/ea_index_unit.sv
module ea_index_unit
  import ea_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] xreg,
  input  logic              shift_mode,
  output ea_word_t          res
);
  logic              idx;
  logic [AW-1:0]     base;
  logic [AW-1:0]     xoff;
  logic [AW-1:0]     full_sum;
  logic [SHF_W-1:0]  low_sum;
  logic              unused_bits;

  assign idx      = word[IDX_BIT];
  assign base     = word[AW-1:0];
  assign xoff     = xreg[AW-1:0];
  assign full_sum = base + xoff;
  assign low_sum  = base[SHF_W-1:0] + xoff[SHF_W-1:0];
  assign unused_bits = ^{word[WORD_W-1], word[IDX_BIT-1:IND_BIT+1], xreg[WORD_W-1:AW]};

  always_comb begin
    res.ind = word[IND_BIT];
    if (!idx) begin
      res.addr = base;
    end else if (shift_mode && !word[IND_BIT]) begin
      res.addr = {base[AW-1:SHF_W], low_sum};
    end else begin
      res.addr = full_sum;
    end
  end
endmodule

// File: rtl/ea_range_check.sv
module ea_range_check
  import ea_pkg::*;
#(
  parameter int MEM_WORDS = 4096
) (
  input  logic [AW-1:0] addr,
  output logic          in_range
);
  localparam int FULL = 1 << AW;

  generate
    if (MEM_WORDS >= FULL) begin : g_full
      logic unused_addr;
      assign unused_addr = ^addr;
      assign in_range    = 1'b1;
    end else begin : g_part
      localparam logic [AW-1:0] LIMIT = AW'(MEM_WORDS);
      assign in_range = (addr < LIMIT);
    end
  endgenerate
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  ea_word_t         dec,
  input  logic             cur_in_range,
  input  logic             mem_valid,
  output logic             busy,
  output logic [AW-1:0]    cur_addr,
  output logic             done,
  output logic [AW-1:0]    ea,
  output logic [LVL_W-1:0] levels
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  ea_state_t         st_q, st_n;
  logic [AW-1:0]     cur_q, cur_n;
  logic [AW-1:0]     ea_q, ea_n;
  logic [LVL_W-1:0]  lvl_q, lvl_n, lvl_inc;
  logic [LVL_W-1:0]  lvo_q, lvo_n;
  logic              done_q, done_n;
  logic              advance;

  assign lvl_inc = (lvl_q == LVL_MAX) ? lvl_q : lvl_q + LVL_ONE;
  assign advance = !cur_in_range || mem_valid;

  always_comb begin
    st_n   = st_q;
    cur_n  = cur_q;
    ea_n   = ea_q;
    lvl_n  = lvl_q;
    lvo_n  = lvo_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          lvl_n = '0;
          if (dec.ind) begin
            cur_n = dec.addr;
            st_n  = ST_READ;
          end else begin
            ea_n   = dec.addr;
            lvo_n  = '0;
            done_n = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (advance) begin
          if (dec.ind) begin
            cur_n = dec.addr;
            lvl_n = lvl_inc;
          end else begin
            ea_n   = dec.addr;
            lvo_n  = lvl_inc;
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      ea_q   <= '0;
      lvl_q  <= '0;
      lvo_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cur_q  <= cur_n;
      ea_q   <= ea_n;
      lvl_q  <= lvl_n;
      lvo_q  <= lvo_n;
      done_q <= done_n;
    end
  end

  assign busy     = (st_q == ST_READ);
  assign cur_addr = cur_q;
  assign done     = done_q;
  assign ea       = ea_q;
  assign levels   = lvo_q;
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  parameter int LVL_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] xreg,
  input  logic              shift_op,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [AW-1:0]     ea,
  output logic [LVL_W-1:0]  ind_levels
);
  logic              busy;
  logic              cur_in_range;
  logic [AW-1:0]     cur_addr;
  logic [WORD_W-1:0] word_sel;
  logic              shift_sel;
  ea_word_t          dec;

  // Idle: decode the instruction; reading: decode the fetched word (zero if out of range)
  assign word_sel  = !busy ? instr : (cur_in_range ? mem_rdata : '0);
  assign shift_sel = !busy && shift_op;

  ea_index_unit u_index (
    .word       (word_sel),
    .xreg       (xreg),
    .shift_mode (shift_sel),
    .res        (dec)
  );

  ea_range_check #(.MEM_WORDS(MEM_WORDS)) u_range (
    .addr     (cur_addr),
    .in_range (cur_in_range)
  );

  ea_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dec          (dec),
    .cur_in_range (cur_in_range),
    .mem_valid    (mem_valid),
    .busy         (busy),
    .cur_addr     (cur_addr),
    .done         (done),
    .ea           (ea),
    .levels       (ind_levels)
  );

  assign mem_req  = busy && cur_in_range;
  assign mem_addr = cur_addr;
endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk
  import ea_pkg::*;
#(
  parameter int MEM_WORDS = 4096,
  parameter int LVL_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_valid,
  input logic              done,
  input logic [AW-1:0]     ea,
  input logic [LVL_W-1:0]  ind_levels
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R9

  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'({1'b0, mem_addr}) < MEM_WORDS)); // R8

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ea) && $stable(ind_levels))); // R10

  AST_DIRECT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ind_levels == '0) |-> !$past(mem_req)); // R3
endmodule

bind ea_resolver ea_resolver_chk #(.MEM_WORDS(MEM_WORDS), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_valid  (mem_valid),
  .done       (done),
  .ea         (ea),
  .ind_levels (ind_levels)
);

// File: tb/ea_resolver_tb.sv
module ea_resolver_tb;
  localparam logic [23:0] IDX = 24'h400000;
  localparam logic [23:0] IND = 24'h004000;

  logic        clk, rst_n, start, shift_op, mem_valid;
  logic [23:0] instr, xreg, mem_rdata;
  logic        mem_req, done;
  logic [13:0] mem_addr, ea;
  logic [5:0]  ind_levels;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int wait_cnt = 0;
  logic [13:0] first_addr;
  bit addr_moved;
  logic [13:0] req_log[$];
  logic [23:0] mem [int];

  logic [13:0] got_ea;
  logic [5:0]  got_lvl;
  int          got_cyc;

  ea_resolver #(.MEM_WORDS(4096), .LVL_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .xreg(xreg),
    .shift_op(shift_op), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .ea(ea),
    .ind_levels(ind_levels)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [23:0] rd(input logic [13:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 24'h0;
  endfunction

  // memory responder: answers after lat waiting cycles
  initial begin
    mem_valid = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        mem_valid = 1'b0;
        wait_cnt  = 0;
      end
      if (mem_req) begin
        if (wait_cnt == 0) first_addr = mem_addr;
        else if (mem_addr != first_addr) addr_moved = 1'b1;
        if (wait_cnt == lat) begin
          mem_valid = 1'b1;
          mem_rdata = rd(mem_addr);
          req_log.push_back(mem_addr);
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic resolve(input logic [23:0] w, input logic [23:0] x, input logic sh, input int l);
    lat = l;
    req_log.delete();
    addr_moved = 1'b0;
    @(negedge clk);
    instr = w; xreg = x; shift_op = sh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_cyc = 1;
    while (!done && got_cyc < 300) begin
      @(negedge clk);
      got_cyc++;
    end
    got_ea  = ea;
    got_lvl = ind_levels;
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R11 done after reset", int'(done), 0);
    chk(mem_req == 1'b0, "R11 mem_req after reset", int'(mem_req), 0);
    chk(ea == 14'h0, "R11 ea after reset", int'(ea), 0);
    chk(ind_levels == 6'h0, "R11 levels after reset", int'(ind_levels), 0);
  endtask

  task automatic t_direct_plain;
    resolve(24'h3A0123, 24'h000777, 1'b0, 0);  // noise in ignored bits, index flag clear
    chk(got_ea == 14'h0123, "R1 direct ea", int'(got_ea), 'h0123);
    chk(got_lvl == 0, "R3 direct levels", int'(got_lvl), 0);
    chk(got_cyc == 1, "R3 direct cycles", got_cyc, 1);
    chk(req_log.size() == 0, "R3 direct no request", req_log.size(), 0);
  endtask

  task automatic t_direct_indexed;
    resolve(IDX | 24'h003FF0, 24'hFFC020, 1'b0, 0);
    chk(got_ea == 14'h0010, "R2 indexed wrap", int'(got_ea), 'h0010);
  endtask

  task automatic t_single_indirect;
    mem[32'h100] = 24'h000200;
    resolve(IND | 24'h000100, 24'h000005, 1'b0, 0);
    chk(got_ea == 14'h0200, "R5 single indirect ea", int'(got_ea), 'h0200);
    chk(got_lvl == 1, "R5 single indirect levels", int'(got_lvl), 1);
    chk(got_cyc == 2, "R9 single indirect cycles", got_cyc, 2);
  endtask

  task automatic t_index_then_fetch;
    mem[32'h105] = 24'h000777;
    resolve(IDX | IND | 24'h000100, 24'h000005, 1'b0, 0);
    chk(req_log.size() == 1 && req_log[0] == 14'h0105, "R4 request at indexed address",
        req_log.size() > 0 ? int'(req_log[0]) : -1, 'h0105);
    chk(got_ea == 14'h0777, "R4 ea after indexed fetch", int'(got_ea), 'h0777);
  endtask

  task automatic t_chain;
    mem[32'h300] = IND | IDX | 24'h000010;
    mem[32'h012] = IND | 24'h000020;
    mem[32'h020] = 24'h3A0ABC;
    resolve(IND | 24'h000300, 24'h000002, 1'b0, 2);
    chk(got_ea == 14'h0ABC, "R5 chain ea", int'(got_ea), 'h0ABC);
    chk(got_lvl == 3, "R5 chain levels", int'(got_lvl), 3);
    chk(req_log.size() == 3 && req_log[1] == 14'h0012, "R5 chain reindexed fetch",
        req_log.size() > 1 ? int'(req_log[1]) : -1, 'h0012);
    chk(got_cyc == 10, "R9 chain cycles with latency", got_cyc, 10);
    chk(!addr_moved, "R9 address held while waiting", int'(addr_moved), 0);
  endtask

  task automatic t_shift;
    resolve(IDX | 24'h002A7A, 24'h00104F, 1'b1, 0);
    chk(got_ea == 14'h2A49, "R6 shift six-bit index", int'(got_ea), 'h2A49);
    resolve(IDX | 24'h002A7A, 24'h00104F, 1'b0, 0);
    chk(got_ea == 14'h3AC9, "R6 same word not shift", int'(got_ea), 'h3AC9);
    mem[32'h441] = 24'h000555;
    resolve(IDX | IND | 24'h000400, 24'h000041, 1'b1, 0);
    chk(req_log.size() == 1 && req_log[0] == 14'h0441, "R7 shift indirect full index",
        req_log.size() > 0 ? int'(req_log[0]) : -1, 'h0441);
    chk(got_ea == 14'h0555, "R7 shift indirect ea", int'(got_ea), 'h0555);
  endtask

  task automatic t_out_of_range;
    mem[32'h1800] = 24'h000777;
    resolve(IND | 24'h001800, 24'h0, 1'b0, 0);
    chk(got_ea == 14'h0, "R8 out of range ea", int'(got_ea), 0);
    chk(got_lvl == 1, "R8 out of range levels", int'(got_lvl), 1);
    chk(got_cyc == 2, "R8 out of range cycles", got_cyc, 2);
    chk(req_log.size() == 0, "R8 no request", req_log.size(), 0);
    mem[32'h050]  = IND | 24'h002000;
    mem[32'h2000] = 24'h000123;
    resolve(IND | 24'h000050, 24'h0, 1'b0, 1);
    chk(got_ea == 14'h0 && got_lvl == 2, "R8 chain into hole",
        int'({got_lvl, got_ea}), int'({6'd2, 14'h0}));
    chk(got_cyc == 4 && req_log.size() == 1, "R8 chain hole cost", got_cyc, 4);
  endtask

  task automatic t_hold;
    resolve(IDX | 24'h000040, 24'h000003, 1'b0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", int'(done), 0);
    instr = IND | 24'h000100;
    repeat (3) @(negedge clk);
    chk(ea == 14'h0043 && ind_levels == 0, "R10 result held", int'(ea), 'h0043);
    chk(mem_req == 1'b0, "R10 idle no request", int'(mem_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; xreg = '0; shift_op = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_direct_plain();
    t_direct_indexed();
    t_single_indirect();
    t_index_then_fetch();
    t_chain();
    t_shift();
    t_out_of_range();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule